// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge PWM Generator

This block drives the four gates of a full bridge from one free-running digital sawtooth. The A/B pair switches one leg and the C/D pair the other. Each pair is complementary and holds close to 50% duty. Each leg changes state once per sawtooth period, so the bridge switches at half the sawtooth rate. The C/D leg lags the A/B leg by a programmed number of clock cycles, and that lag sets how much power the bridge delivers. When the phase word changes, the C/D half-cycle is lengthened or shortened for one period, so the new lag applies from the next period.

Each leg has its own dead-time word. After every change of state in a leg, both outputs of that leg stay low for that many cycles. The other leg is not affected. A value of zero gives plain complementary switching.

Two conditions turn the outputs off:
- **Overcurrent.** An overcurrent input turns all gates off at once. The block then runs a soft-stop, which ramps the phase limit down, and after that a full soft-start, which ramps the phase limit from zero back up to the commanded phase.
- **Light load.** A load-level word feeds a comparator with hysteresis. It shuts the bridge off below a low threshold and lets it run again only above a higher threshold.

Top module: `psfb_pwm`

## Requirements
- R1: The sawtooth count restarts at 0 after reaching `periodIn`, so one period is `periodIn`+1 clocks. `syncOut` is high in exactly the clock in which the count equals or exceeds `periodIn`, which is once per period.
- R2: The A/B leg state toggles on every sawtooth wrap. `outA` follows the leg state high and `outB` follows it low, so `outA` and `outB` are never high together.
- R3: The C/D leg toggles at the clock edge where the next count equals the effective phase. `outC` therefore lags `outA` by that many clocks, and a phase of 0 means the two legs are in step. `outC` and `outD` are never high together.
- R4: The phase word is captured only at the wrap, and it is clamped to at most `periodIn`.
- R5: After each toggle of a leg, both outputs of that leg stay low for the dead-time word sampled at the toggle edge. Each leg uses its own word (`deadAB` or `deadCD`), and a word of 0 gives no gap.
- R6: A ramp level k steps from 0 to 2^RAMP_SHIFT, advancing by one per wrap. During this soft-start the captured phase is floor(`phaseIn`·k / 2^RAMP_SHIFT). Once the ramp is full, the block runs with the full phase.
- R7: After a change of `phaseIn`, the C/D leg still toggles exactly once per sawtooth period. Its half-cycle is lengthened or shortened so that it takes up the new lag.
- R8: While `ocFault` is high, all four outputs are low in the same clock. The block then enters soft-stop. In soft-stop k drops by one per wrap, and the outputs stay low until the fault is gone and k is 0. Soft-start then begins again from k = 0.
- R9: From the clock after `loadLevel` < LL_LO (default 500), all outputs are held low. They are released only from the clock after `loadLevel` > LL_HI (default 600). Levels between the two thresholds change nothing.
- R10: During reset and for the first clock after it, all outputs are low, and `syncOut` is low when `periodIn` > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| periodIn | input | CNT_W | Last count value of the sawtooth |
| phaseIn | input | CNT_W | Commanded C/D lag in clocks |
| deadAB | input | DT_W | Dead time of the A/B leg in clocks |
| deadCD | input | DT_W | Dead time of the C/D leg in clocks |
| ocFault | input | 1 | Overcurrent fault |
| loadLevel | input | LVL_W | Control level for light-load shutdown |
| syncOut | output | 1 | One-clock pulse at each sawtooth wrap |
| outA | output | 1 | A/B leg, high side |
| outB | output | 1 | A/B leg, low side |
| outC | output | 1 | C/D leg, high side |
| outD | output | 1 | C/D leg, low side |

## Verification
A fault in the count or in the captured phase shows up within one sawtooth period, as a wrong `syncOut` spacing or as a shifted C/D edge. A wrong ramp level or sequencer state stays hidden while the outputs are gated off. It becomes visible at the first C/D edge after the bridge is enabled again, as a lag that differs from floor(`phaseIn`·k / 2^RAMP_SHIFT). A dead-time counter that is off by one moves a single rising edge by one clock in the leg after that toggle. The bench model is compared against all five outputs on every clock, so each of these faults is caught in the cycle where it first appears.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  // Sequencer states: gates off / ramping up / full phase
  typedef enum logic [1:0] {
    SEQ_STOP  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_RUN   = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic outEnable;   // gates may be driven
    logic phaseFull;   // ramp complete, use commanded phase directly
  } ctrlStrobe_t;

endpackage

// File: rtl/psfb_deadband.sv
// One bridge leg: toggling state plus dead-time gap after each toggle.
module psfb_deadband #(
  parameter int unsigned DT_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            toggle,
  input  logic [DT_W-1:0] deadVal,
  input  logic            enable,
  output logic            outHigh,
  output logic            outLow
);

  logic            legState;
  logic [DT_W-1:0] gapCnt;
  logic            gapDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      legState <= 1'b0;
      gapCnt   <= '0;
    end else if (toggle) begin
      legState <= ~legState;
      gapCnt   <= deadVal;
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  assign gapDone = (gapCnt == '0);
  assign outHigh = enable && gapDone && legState;
  assign outLow  = enable && gapDone && !legState;

endmodule

// File: rtl/psfb_datapath.sv
// Sawtooth, phase capture with soft-start scaling, and the two legs.
module psfb_datapath
  import psfb_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned DT_W       = 6,
  parameter int unsigned RAMP_SHIFT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    periodIn,
  input  logic [CNT_W-1:0]    phaseIn,
  input  logic [DT_W-1:0]     deadAB,
  input  logic [DT_W-1:0]     deadCD,
  input  ctrlStrobe_t         strobe,
  input  logic [RAMP_SHIFT:0] rampLevel,
  output logic                wrap,
  output logic                outA,
  output logic                outB,
  output logic                outC,
  output logic                outD
);

  localparam int unsigned PROD_W = CNT_W + RAMP_SHIFT + 1;
  localparam int unsigned NUM_LEGS = 2;

  logic [CNT_W-1:0]  sawCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic [PROD_W-1:0] rampProd;
  logic [CNT_W-1:0]  scaledPhase;
  logic [CNT_W-1:0]  rampedPhase;
  logic [CNT_W-1:0]  clampPhase;
  logic [CNT_W-1:0]  phaseEff;
  logic [CNT_W-1:0]  phaseNext;
  logic              cdToggle;
  logic              unusedProdBits;

  // Sawtooth
  assign wrap    = (sawCnt >= periodIn);
  assign nextCnt = wrap ? '0 : sawCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sawCnt <= '0;
    else       sawCnt <= nextCnt;
  end

  // Soft-start scaling: phase * k / 2^RAMP_SHIFT
  assign rampProd = {{(RAMP_SHIFT+1){1'b0}}, phaseIn} * {{CNT_W{1'b0}}, rampLevel};
  assign scaledPhase = rampProd[CNT_W+RAMP_SHIFT-1:RAMP_SHIFT];
  assign unusedProdBits = ^{rampProd[PROD_W-1], rampProd[RAMP_SHIFT-1:0]};
  assign rampedPhase = strobe.phaseFull ? phaseIn : scaledPhase;
  assign clampPhase  = (rampedPhase > periodIn) ? periodIn : rampedPhase;

  // Phase captured at wrap; C/D edge when the next count meets it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     phaseEff <= '0;
    else if (wrap) phaseEff <= clampPhase;
  end

  assign phaseNext = wrap ? clampPhase : phaseEff;
  assign cdToggle  = (nextCnt == phaseNext);

  // Two independent legs
  logic [NUM_LEGS-1:0] legToggle;
  logic [DT_W-1:0]     legDead [NUM_LEGS];
  logic [NUM_LEGS-1:0] legHigh;
  logic [NUM_LEGS-1:0] legLow;

  assign legToggle  = {cdToggle, wrap};
  assign legDead[0] = deadAB;
  assign legDead[1] = deadCD;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_deadband #(.DT_W(DT_W)) u_leg (
      .clk     (clk),
      .rstN    (rstN),
      .toggle  (legToggle[g]),
      .deadVal (legDead[g]),
      .enable  (strobe.outEnable),
      .outHigh (legHigh[g]),
      .outLow  (legLow[g])
    );
  end

  assign outA = legHigh[0];
  assign outB = legLow[0];
  assign outC = legHigh[1];
  assign outD = legLow[1];

endmodule

// File: rtl/psfb_ctrl.sv
// Stop/start sequencer and light-load comparator with hysteresis.
module psfb_ctrl
  import psfb_pkg::*;
#(
  parameter int unsigned RAMP_SHIFT = 3,
  parameter int unsigned LVL_W      = 10,
  parameter int unsigned LL_LO      = 500,
  parameter int unsigned LL_HI      = 600
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrap,
  input  logic                ocFault,
  input  logic [LVL_W-1:0]    loadLevel,
  output ctrlStrobe_t         strobe,
  output logic [RAMP_SHIFT:0] rampLevel
);

  localparam logic [RAMP_SHIFT:0] FULL_LVL = {1'b1, {RAMP_SHIFT{1'b0}}};
  localparam logic [LVL_W-1:0]    LO_T     = LVL_W'(LL_LO);
  localparam logic [LVL_W-1:0]    HI_T     = LVL_W'(LL_HI);

  seqState_t seqState;
  logic      lightOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState  <= SEQ_STOP;
      rampLevel <= '0;
    end else begin
      case (seqState)
        SEQ_STOP: begin
          if (wrap && rampLevel != '0) rampLevel <= rampLevel - 1'b1;
          if (!ocFault && rampLevel == '0) seqState <= SEQ_START;
        end
        SEQ_START: begin
          if (ocFault)                   seqState  <= SEQ_STOP;
          else if (rampLevel == FULL_LVL) seqState <= SEQ_RUN;
          else if (wrap)                 rampLevel <= rampLevel + 1'b1;
        end
        SEQ_RUN: begin
          if (ocFault) seqState <= SEQ_STOP;
        end
        default: seqState <= SEQ_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lightOff <= 1'b0;
    else if (loadLevel < LO_T) lightOff <= 1'b1;
    else if (loadLevel > HI_T) lightOff <= 1'b0;
  end

  assign strobe.outEnable = (seqState != SEQ_STOP) && !ocFault && !lightOff;
  assign strobe.phaseFull = (seqState == SEQ_RUN);

endmodule

// File: rtl/psfb_pwm.sv
// Top: phase-shifted full-bridge gate generator.
module psfb_pwm
  import psfb_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned DT_W       = 6,
  parameter int unsigned LVL_W      = 10,
  parameter int unsigned RAMP_SHIFT = 3,
  parameter int unsigned LL_LO      = 500,
  parameter int unsigned LL_HI      = 600
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] phaseIn,
  input  logic [DT_W-1:0]  deadAB,
  input  logic [DT_W-1:0]  deadCD,
  input  logic             ocFault,
  input  logic [LVL_W-1:0] loadLevel,
  output logic             syncOut,
  output logic             outA,
  output logic             outB,
  output logic             outC,
  output logic             outD
);

  ctrlStrobe_t         strobe;
  logic [RAMP_SHIFT:0] rampLevel;
  logic                wrap;

  psfb_ctrl #(
    .RAMP_SHIFT (RAMP_SHIFT),
    .LVL_W      (LVL_W),
    .LL_LO      (LL_LO),
    .LL_HI      (LL_HI)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrap      (wrap),
    .ocFault   (ocFault),
    .loadLevel (loadLevel),
    .strobe    (strobe),
    .rampLevel (rampLevel)
  );

  psfb_datapath #(
    .CNT_W      (CNT_W),
    .DT_W       (DT_W),
    .RAMP_SHIFT (RAMP_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .periodIn  (periodIn),
    .phaseIn   (phaseIn),
    .deadAB    (deadAB),
    .deadCD    (deadCD),
    .strobe    (strobe),
    .rampLevel (rampLevel),
    .wrap      (wrap),
    .outA      (outA),
    .outB      (outB),
    .outC      (outC),
    .outD      (outD)
  );

  assign syncOut = wrap;

endmodule

// File: rtl/psfb_pwm_chk.sv
// Port-level properties of psfb_pwm, bound to every instance.
module psfb_pwm_chk #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned DT_W  = 6,
  parameter int unsigned LVL_W = 10,
  parameter int unsigned LL_LO = 500
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] periodIn,
  input logic [DT_W-1:0]  deadAB,
  input logic [DT_W-1:0]  deadCD,
  input logic             ocFault,
  input logic [LVL_W-1:0] loadLevel,
  input logic             syncOut,
  input logic             outA,
  input logic             outB,
  input logic             outC,
  input logic             outD
);

  localparam logic [LVL_W-1:0] LO_T = LVL_W'(LL_LO);

  // R1: a wrap is followed by a non-wrap clock unless the period is zero
  a_r1_sync_single: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |=> (!syncOut || periodIn == '0));

  // R2: A/B never overlap
  a_r2_ab_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(outA && outB));

  // R3: C/D never overlap
  a_r3_cd_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(outC && outD));

  // R5: a nonzero A/B gap keeps A low in the clock where B drops
  a_r5_gap_ab: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(outB) && $past(deadAB) != '0) |-> !outA);

  // R5: same for the C/D leg
  a_r5_gap_cd: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(outD) && $past(deadCD) != '0) |-> !outC);

  // R8: the clock after a fault the sequencer still holds the gates off
  a_r8_fault_off: assert property (@(posedge clk) disable iff (!rstN)
    ocFault |=> !(outA || outB || outC || outD));

  // R9: a low load level disables the bridge from the next clock
  a_r9_light_off: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadLevel) < LO_T) |-> !(outA || outB || outC || outD));

endmodule

bind psfb_pwm psfb_pwm_chk #(
  .CNT_W (CNT_W),
  .DT_W  (DT_W),
  .LVL_W (LVL_W),
  .LL_LO (LL_LO)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .periodIn  (periodIn),
  .deadAB    (deadAB),
  .deadCD    (deadCD),
  .ocFault   (ocFault),
  .loadLevel (loadLevel),
  .syncOut   (syncOut),
  .outA      (outA),
  .outB      (outB),
  .outC      (outC),
  .outD      (outD)
);

// File: tb/psfb_pwm_test.sv
module psfb_pwm_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam int DT_W  = 6;
  localparam int LVL_W = 10;
  localparam int RS    = 3;
  localparam int FULL  = 1 << RS;

  logic             clk = 1'b0;
  logic             rstN;
  logic [CNT_W-1:0] periodIn;
  logic [CNT_W-1:0] phaseIn;
  logic [DT_W-1:0]  deadAB;
  logic [DT_W-1:0]  deadCD;
  logic             ocFault;
  logic [LVL_W-1:0] loadLevel;
  logic             syncOut, outA, outB, outC, outD;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    checkEn = 0;
  string tag     = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  psfb_pwm #(.CNT_W(CNT_W), .DT_W(DT_W), .LVL_W(LVL_W), .RAMP_SHIFT(RS)) uut (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .phaseIn(phaseIn),
    .deadAB(deadAB), .deadCD(deadCD), .ocFault(ocFault), .loadLevel(loadLevel),
    .syncOut(syncOut), .outA(outA), .outB(outB), .outC(outC), .outD(outD)
  );

  // Behavioural reference model (state: 0 ramping, 1 running, 2 stopped)
  int mCnt, mLegAB, mLegCD, mDtAB, mDtCD, mSt, mK, mLl, mPh;
  int nc, lim, phN, nSt, nK;
  bit w, cdT;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mLegAB = 0; mLegCD = 0; mDtAB = 0; mDtCD = 0;
      mSt = 2; mK = 0; mLl = 0; mPh = 0;
    end else begin
      w   = (mCnt >= int'(periodIn));
      nc  = w ? 0 : mCnt + 1;
      lim = (int'(phaseIn) * mK) / FULL;
      if (lim > int'(periodIn)) lim = int'(periodIn);
      phN = w ? lim : mPh;
      cdT = (nc == phN);
      nSt = mSt; nK = mK;
      if (mSt == 2) begin
        if (w && mK > 0) nK = mK - 1;
        if (!ocFault && mK == 0) nSt = 0;
      end else if (mSt == 0) begin
        if (ocFault) nSt = 2;
        else if (mK == FULL) nSt = 1;
        else if (w) nK = mK + 1;
      end else if (ocFault) nSt = 2;
      if (int'(loadLevel) < 500) mLl = 1;
      else if (int'(loadLevel) > 600) mLl = 0;
      if (w) begin mLegAB = 1 - mLegAB; mDtAB = int'(deadAB); end
      else if (mDtAB > 0) mDtAB--;
      if (cdT) begin mLegCD = 1 - mLegCD; mDtCD = int'(deadCD); end
      else if (mDtCD > 0) mDtCD--;
      mPh = phN; mCnt = nc; mSt = nSt; mK = nK;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (checkEn) begin
      automatic bit en = (mSt != 2) && !ocFault && (mLl == 0);
      automatic bit eA = en && mLegAB == 1 && mDtAB == 0;
      automatic bit eB = en && mLegAB == 0 && mDtAB == 0;
      automatic bit eC = en && mLegCD == 1 && mDtCD == 0;
      automatic bit eD = en && mLegCD == 0 && mDtCD == 0;
      automatic bit eS = (mCnt >= int'(periodIn));
      chk(syncOut == eS, "R1", "syncOut", int'(syncOut), int'(eS));
      chk(outA == eA, tag, "outA", int'(outA), int'(eA));
      chk(outB == eB, tag, "outB", int'(outB), int'(eB));
      chk(outC == eC, tag, "outC", int'(outC), int'(eC));
      chk(outD == eD, tag, "outD", int'(outD), int'(eD));
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; periodIn = 19; phaseIn = 8; deadAB = 3; deadCD = 5;
    ocFault = 1'b0; loadLevel = 800;
    run(3);
    #2;
    // R10: reset state
    chk({outA, outB, outC, outD, syncOut} == 5'b0, "R10", "outputs in reset",
        int'({outA, outB, outC, outD, syncOut}), 0);
    @(negedge clk);
    rstN = 1'b1;
    checkEn = 1;
    #2;
    chk({outA, outB, outC, outD} == 4'b0, "R10", "outputs after reset",
        int'({outA, outB, outC, outD}), 0);
    tag = "R6";
    run(300);
    tag = "R2";
    run(120);
    // R1: one sync pulse per 20 clocks
    begin
      automatic int nSync = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk); #2;
        if (syncOut) nSync++;
      end
      chk(nSync == 10, "R1", "sync pulses in 200 clocks", nSync, 10);
    end
    tag = "R3";
    run(120);
    tag = "R7";
    phaseIn = 15; run(120);
    phaseIn = 2;  run(120);
    tag = "R3";
    phaseIn = 0;  run(100);
    tag = "R4";
    phaseIn = 40; run(120);
    tag = "R5";
    phaseIn = 8; deadCD = 0; run(120);
    deadAB = 0; deadCD = 7; run(120);
    tag = "R8";
    @(negedge clk);
    ocFault = 1'b1;
    #2;
    chk({outA, outB, outC, outD} == 4'b0, "R8", "outputs with fault",
        int'({outA, outB, outC, outD}), 0);
    run(3);
    ocFault = 1'b0;
    run(450);
    ocFault = 1'b1; run(1);
    ocFault = 1'b0; run(420);
    tag = "R9";
    loadLevel = 450; run(30);
    loadLevel = 550; run(50);
    #2;
    chk({outA, outB, outC, outD} == 4'b0, "R9", "outputs in hysteresis band",
        int'({outA, outB, outC, outD}), 0);
    run(1);
    loadLevel = 650; run(50);
    #2;
    chk((outA || outB) == 1'b1, "R9", "A/B after release", int'(outA || outB), 1);
    run(1);
    loadLevel = 550; run(60);
    tag = "R1";
    periodIn = 9; run(200);
    finishRun();
  end

endmodule